// File: doc/BRIEF.md
# Multi-mode programmable interval counter

This block is a single channel of a 16-bit programmable interval timer. It advances on a qualified tick, not on every clock. It measures the ticks that have elapsed since the last restart, and from that elapsed count it derives an output level and a readable count value. A 3-bit mode code chooses the waveform:

- terminal-count flag
- retriggerable one-shot window
- rate pulse
- square wave
- software strobe
- hardware-triggered strobe

A load strobe supplies a new initial count and mode. The value is held pending and takes effect on the next tick. A rising gate edge also restarts the channel, but only in the modes that are retriggerable. A host bus interface can latch the count output. Bus decoding, decimal counting and arbitration between channels all belong outside this block.

The parameter `CHANNEL_ID` sets the gate level that the edge detector assumes at reset. Channels 0 and 1 assume the gate is high. Channel 2 assumes it is low, so a high gate seen after reset counts as a rising edge.

Top module: `pit_channel`

## Requirements
- R1: A loaded initial count of 0 is treated as a span of 65536 ticks; right after such a load takes effect, `count_val` reads 0x0000.
- R2: Mode code 0: `out_level` is low while elapsed ticks < span and high from the tick where elapsed reaches the span onward, until the next restart.
- R3: Mode code 1: `out_level` is high while elapsed ticks < span and low afterwards.
- R4: Mode code 2: `out_level` is high exactly when elapsed ticks is a nonzero multiple of the span, otherwise low; the period repeats without reloading.
- R5: Mode code 3: with r = elapsed mod span, `out_level` is high while r < (span+1)/2 and low otherwise.
- R6: Mode codes 4 and 5: `out_level` is high only while elapsed ticks equals the span, a single-tick strobe with no later transition.
- R7: A gate rising edge restarts the elapsed count at the next tick in mode codes 1, 2, 3 and 5; in mode codes 0 and 4 it has no effect on output or count.
- R8: `count_val` reads (span − elapsed) mod 65536 in mode codes 0, 1, 4 and 5, (span − elapsed mod span) mod 65536 in mode code 2, and (span − (2·elapsed) mod span) mod 65536 in mode code 3.
- R9: After reset the channel is in mode code 3 with span 65536 and elapsed 0 (`out_level` high, `count_val` 0x0000), and the gate edge detector starts at 1 for channels 0 and 1 and at 0 for channel 2.
- R10: A load (`load_stb` high for one cycle) or a gate edge is held pending and restarts the channel on the first later clock with `tick_en` high, where elapsed becomes 0; until then the old behaviour continues.
- R11: Mode codes 6 and 7 behave as mode codes 2 and 3 respectively.
- R12: In a cycle with `tick_en` low, neither `out_level` nor `count_val` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_en | input | 1 | counting tick qualifier |
| gate_in | input | 1 | gate / trigger input, sampled each clock |
| load_stb | input | 1 | one-cycle strobe accepting `load_val` and `mode_sel` |
| load_val | input | 16 | initial count (0 means 65536) |
| mode_sel | input | 3 | waveform mode code |
| out_level | output | 1 | timer output level |
| count_val | output | 16 | current readable count |

## Verification
The assertions assume that `gate_in`, `load_stb` and `tick_en` are synchronous to `clk` and hold a defined value in every cycle after reset. They also assume that a restart happens only on a tick. The mode-specific properties apply only to a channel that has not restarted in the cycle under check. The stimulus drives every input on the falling edge, so all of them are stable at the rising edge. It includes loads and gate pulses that fall both in tick and in idle cycles, and stretches with irregular ticks, so pending events wait across cycles with `tick_en` low.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pit_mode_e;

    // Codes 6 and 7 fold onto the two periodic modes.
    function automatic pit_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return pit_mode_e'(code);
        endcase
    endfunction

    function automatic logic gate_retriggers(input pit_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE)  || (m == M_HWSTROBE);
    endfunction

    function automatic logic is_periodic(input pit_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic is_strobe(input pit_mode_e m);
        return (m == M_SWSTROBE) || (m == M_HWSTROBE);
    endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit GATE_RST = 1'b1,
    localparam int SPAN_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              gate_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  init_i,
    input  logic [2:0]        code_i,
    input  pit_mode_e         cur_mode_i,
    output logic              restart_o,
    output logic              apply_o,
    output logic [SPAN_W-1:0] new_span_o,
    output pit_mode_e         new_mode_o
);

    localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(1) << CNT_W;

    logic              gate_q;
    logic              pend_ld;
    logic              pend_trig;
    logic [SPAN_W-1:0] pend_span;
    pit_mode_e         pend_mode;

    logic rise;
    assign rise = gate_i & ~gate_q;

    // Only events registered before this clock may act on a tick.
    assign apply_o    = tick_i & pend_ld;
    assign restart_o  = tick_i & (pend_ld | (pend_trig & gate_retriggers(cur_mode_i)));
    assign new_span_o = pend_span;
    assign new_mode_o = pend_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= GATE_RST;
            pend_ld   <= 1'b0;
            pend_trig <= 1'b0;
            pend_span <= FULL_SPAN;
            pend_mode <= M_SQUARE;
        end else begin
            gate_q    <= gate_i;
            pend_ld   <= (pend_ld & ~tick_i) | load_i;
            pend_trig <= (pend_trig & ~tick_i) | rise;
            if (load_i) begin
                pend_span <= (init_i == '0) ? FULL_SPAN : {1'b0, init_i};
                pend_mode <= decode_mode(code_i);
            end
        end
    end

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W   = 16,
    localparam int SPAN_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic              apply_i,
    input  logic [SPAN_W-1:0] new_span_i,
    input  pit_mode_e         new_mode_i,
    output pit_mode_e         mode_o,
    output logic [SPAN_W-1:0] span_o,
    output logic [SPAN_W-1:0] phase_o,
    output logic [CNT_W-1:0]  wrap_o,
    output logic              past_o,
    output logic              started_o
);

    localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(1) << CNT_W;

    logic [SPAN_W-1:0] phase_nxt;
    assign phase_nxt = phase_o + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o    <= M_SQUARE;
            span_o    <= FULL_SPAN;
            phase_o   <= '0;
            wrap_o    <= '0;
            past_o    <= 1'b0;
            started_o <= 1'b0;
        end else if (restart_i) begin
            if (apply_i) begin
                mode_o <= new_mode_i;
                span_o <= new_span_i;
            end
            wrap_o    <= apply_i ? new_span_i[CNT_W-1:0] : span_o[CNT_W-1:0];
            phase_o   <= '0;
            past_o    <= 1'b0;
            started_o <= 1'b0;
        end else if (tick_i) begin
            started_o <= 1'b1;
            wrap_o    <= wrap_o - 1'b1;
            if (is_periodic(mode_o)) begin
                phase_o <= (phase_nxt == span_o) ? '0 : phase_nxt;
            end else if (phase_o == span_o) begin
                past_o <= 1'b1;
            end else begin
                phase_o <= phase_nxt;
            end
        end
    end

endmodule

// File: rtl/pit_decode.sv
module pit_decode
    import pit_pkg::*;
#(
    parameter int CNT_W   = 16,
    localparam int SPAN_W = CNT_W + 1
) (
    input  pit_mode_e         mode_i,
    input  logic [SPAN_W-1:0] span_i,
    input  logic [SPAN_W-1:0] phase_i,
    input  logic [CNT_W-1:0]  wrap_i,
    input  logic              past_i,
    input  logic              started_i,
    output logic              out_o,
    output logic [CNT_W-1:0]  count_o
);

    // Remaining count for the square wave, which moves two steps per tick.
    function automatic logic [CNT_W-1:0] square_left(input logic [SPAN_W-1:0] span,
                                                     input logic [SPAN_W-1:0] phase);
        logic [SPAN_W:0] dbl;
        logic [SPAN_W:0] fold;
        dbl  = {phase, 1'b0};
        fold = (dbl >= {1'b0, span}) ? dbl - {1'b0, span} : dbl;
        return span[CNT_W-1:0] - fold[CNT_W-1:0];
    endfunction

    logic [SPAN_W-1:0] half;
    assign half = SPAN_W'((span_i + 1'b1) >> 1);

    always_comb begin
        unique case (mode_i)
            M_TERM:     out_o = (phase_i == span_i);
            M_ONESHOT:  out_o = (phase_i != span_i);
            M_RATE:     out_o = (phase_i == '0) && started_i;
            M_SQUARE:   out_o = (phase_i < half);
            default:    out_o = (phase_i == span_i) && !past_i;
        endcase
    end

    always_comb begin
        unique case (mode_i)
            M_RATE:   count_o = span_i[CNT_W-1:0] - phase_i[CNT_W-1:0];
            M_SQUARE: count_o = square_left(span_i, phase_i);
            default:  count_o = wrap_i;
        endcase
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int CHANNEL_ID = 0,
    localparam int SPAN_W    = CNT_W + 1,
    localparam bit GATE_RST  = (CHANNEL_ID != 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             gate_in,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode_sel,
    output logic             out_level,
    output logic [CNT_W-1:0] count_val
);

    logic              restart;
    logic              apply;
    logic [SPAN_W-1:0] new_span;
    pit_mode_e         new_mode;
    pit_mode_e         cur_mode;
    logic [SPAN_W-1:0] cur_span;
    logic [SPAN_W-1:0] phase;
    logic [CNT_W-1:0]  wrap;
    logic              past;
    logic              started;

    pit_ctrl #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_en),
        .gate_i     (gate_in),
        .load_i     (load_stb),
        .init_i     (load_val),
        .code_i     (mode_sel),
        .cur_mode_i (cur_mode),
        .restart_o  (restart),
        .apply_o    (apply),
        .new_span_o (new_span),
        .new_mode_o (new_mode)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_en),
        .restart_i  (restart),
        .apply_i    (apply),
        .new_span_i (new_span),
        .new_mode_i (new_mode),
        .mode_o     (cur_mode),
        .span_o     (cur_span),
        .phase_o    (phase),
        .wrap_o     (wrap),
        .past_o     (past),
        .started_o  (started)
    );

    pit_decode #(.CNT_W(CNT_W)) u_decode (
        .mode_i     (cur_mode),
        .span_i     (cur_span),
        .phase_i    (phase),
        .wrap_i     (wrap),
        .past_i     (past),
        .started_i  (started),
        .out_o      (out_level),
        .count_o    (count_val)
    );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CNT_W   = 16,
    localparam int SPAN_W = CNT_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              out_level,
    input logic [CNT_W-1:0]  count_val,
    input logic              restart,
    input pit_mode_e         mode,
    input logic [SPAN_W-1:0] span
);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(out_level) && $stable(count_val));

    p_term_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TERM) && out_level && !restart |=> out_level);

    p_window_closed_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ONESHOT) && !out_level && !restart |=> !out_level);

    p_rate_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RATE) && out_level && tick_en && !restart && (span > 1) |=> !out_level);

    p_strobe_once_r6: assert property (@(posedge clk) disable iff (rst)
        is_strobe(mode) && out_level && tick_en && !restart |=> !out_level);

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        !is_periodic(mode) && tick_en && !restart |=> count_val == $past(count_val) - 1'b1);

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .out_level (out_level),
    .count_val (count_val),
    .restart   (restart),
    .mode      (cur_mode),
    .span      (cur_span)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 65536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        gate_in = 1'b1;
    logic        load_stb = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_sel = '0;
    logic        out_level;
    logic [15:0] count_val;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R9";

    pit_channel u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
        .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
        .out_level(out_level), .count_val(count_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: elapsed ticks since restart, formulas from the requirements.
    int m_mode, m_span, m_d, m_pspan, m_pmode;
    bit m_gprev, m_pld, m_ptrig;

    function automatic int fold_code(input int c);
        if (c == 6) return 2;
        if (c == 7) return 3;
        return c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3; m_span = FULL; m_d = 0; m_gprev = 1'b1;
            m_pld = 0; m_ptrig = 0; m_pspan = FULL; m_pmode = 3;
        end else begin
            if (tick_en) begin
                if (m_pld) begin
                    m_mode = m_pmode; m_span = m_pspan; m_d = 0;
                end else if (m_ptrig && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
                    m_d = 0;
                end else begin
                    m_d++;
                end
                m_pld = 0; m_ptrig = 0;
            end
            if (load_stb) begin
                m_pld = 1;
                m_pspan = (load_val == 0) ? FULL : int'(load_val);
                m_pmode = fold_code(int'(mode_sel));
            end
            if (gate_in && !m_gprev) m_ptrig = 1;
            m_gprev = gate_in;
        end
    end

    function automatic bit exp_out();
        case (m_mode)
            0:       return m_d >= m_span;
            1:       return m_d < m_span;
            2:       return (m_d % m_span == 0) && (m_d != 0);
            3:       return (m_d % m_span) < ((m_span + 1) / 2);
            default: return m_d == m_span;
        endcase
    endfunction

    function automatic int exp_cnt();
        int v;
        case (m_mode)
            2:       v = m_span - (m_d % m_span);
            3:       v = m_span - ((2 * m_d) % m_span);
            default: v = m_span - m_d;
        endcase
        return ((v % FULL) + FULL) % FULL;
    endfunction

    task automatic compare();
        bit eo;
        int ec;
        eo = exp_out();
        ec = exp_cnt();
        checks++;
        if (out_level !== eo || int'(count_val) != ec) begin
            errors++;
            $display("FAIL %s out=%0d exp %0d count=%0d exp %0d (mode %0d elapsed %0d)",
                     cur_req, out_level, eo, count_val, ec, m_mode, m_d);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input bit irregular);
        for (int i = 0; i < n; i++) begin
            cyc();
            tick_en = irregular ? (($urandom % 3) != 0) : 1'b1;
        end
    endtask

    task automatic do_load(input int code, input int val);
        cyc();
        tick_en = 1'b0; load_stb = 1'b1; mode_sel = 3'(code); load_val = 16'(val);
        cyc();
        load_stb = 1'b0; tick_en = 1'b1;
    endtask

    task automatic gate_pulse();
        cyc(); gate_in = 1'b0;
        cyc(); cyc(); gate_in = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state, then count with gate held high (no false edge on channel 0)
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cur_req = "R9";
        cyc();
        checks++;
        if (out_level !== 1'b1 || count_val !== 16'h0000) begin
            errors++;
            $display("FAIL R9 reset out=%0d exp 1 count=%0d exp 0", out_level, count_val);
        end
        tick_en = 1'b1;
        run(10, 0);

        // R10: load held pending across idle cycles
        cur_req = "R10";
        cyc(); tick_en = 1'b0; load_stb = 1'b1; mode_sel = 3'd0; load_val = 16'd7;
        cyc(); load_stb = 1'b0;
        run(1, 0); tick_en = 1'b0;
        cyc(); cyc(); cyc();
        checks++;
        if (count_val == 16'd7) begin
            errors++;
            $display("FAIL R10 count=%0d exp not 7 before tick", count_val);
        end
        tick_en = 1'b1;
        run(10, 0);

        cur_req = "R2";
        do_load(0, 5);
        run(12, 1);
        cur_req = "R7"; gate_pulse(); run(6, 0);

        cur_req = "R3";
        do_load(1, 4);
        run(7, 0);
        cur_req = "R7"; gate_pulse(); run(8, 1);

        cur_req = "R4";
        do_load(2, 3);
        run(10, 0);
        cur_req = "R7"; gate_pulse(); run(6, 0);
        cur_req = "R11";
        do_load(6, 4);
        run(10, 1);

        cur_req = "R5";
        do_load(3, 5);
        run(15, 0);
        cur_req = "R11";
        do_load(7, 4);
        run(10, 0);
        cur_req = "R7"; gate_pulse(); run(8, 0);

        cur_req = "R6";
        do_load(4, 3);
        run(8, 0);
        cur_req = "R7"; gate_pulse(); run(4, 0);
        cur_req = "R6";
        do_load(5, 2);
        run(5, 0);
        cur_req = "R7"; gate_pulse(); run(6, 0);

        cur_req = "R1";
        do_load(0, 0);
        cyc();
        checks++;
        if (count_val !== 16'h0000) begin
            errors++;
            $display("FAIL R1 count=%0d exp 0", count_val);
        end
        run(5, 0);
        do_load(3, 0);
        run(6, 0);

        cur_req = "R8";
        do_load(1, 2);
        run(8, 0);

        cur_req = "R12";
        do_load(2, 5);
        for (int k = 0; k < 6; k++) begin
            tick_en = 1'b0; run(3, 0);
            cyc(); tick_en = 1'b0;
            cyc(); tick_en = 1'b1;
        end
        run(20, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule